// File: doc/BRIEF.md
# Clamping Unsigned Add/Subtract Slice

This block adds or subtracts two unsigned operands in a single combinational ripple-carry chain. Unlike a plain adder, it never wraps around. When an addition overflows, the output pins to the largest representable value. When a subtraction would go below zero, the output pins to zero. Saturating arithmetic of this kind suits pixel and sample processing, where a wrapped value produces a far worse artefact than a clipped one.

A single mode input selects the operation. For subtraction the block inverts the second operand bit by bit and feeds the mode bit in as the carry into the lowest stage. The clamp decision needs only one gate: the carry out of the top stage XOR the mode bit. That flag steers a row of two-input selectors, each choosing between its raw sum bit and the fill value. The raw top carry is also exported, so that a wider partitioned adder can chain or inspect its slices.

Top module: `sat_addsub`

## Requirements
- R1: With `sub_mode` = 0 and `opnd_a + opnd_b` ≤ 2^WIDTH−1, `result` equals the true sum and `clamped` is 0.
- R2: With `sub_mode` = 0 and `opnd_a + opnd_b` > 2^WIDTH−1, `result` is all ones and `clamped` is 1.
- R3: With `sub_mode` = 1 and `opnd_a` ≥ `opnd_b`, `result` equals `opnd_a − opnd_b` and `clamped` is 0.
- R4: With `sub_mode` = 1 and `opnd_a` < `opnd_b`, `result` is all zeros and `clamped` is 1.
- R5: `carry_out` is the carry from the top stage of `opnd_a + (opnd_b XOR {WIDTH{sub_mode}}) + sub_mode`. In addition mode it is 1 exactly on overflow. In subtraction mode it is 1 exactly when `opnd_a` ≥ `opnd_b`.
- R6: `clamped` equals `carry_out` XOR `sub_mode`, so it is 1 exactly when the output has been forced.
- R7: The limits themselves do not saturate. A sum of exactly 2^WIDTH−1 passes through unclamped. A difference of exactly zero (`opnd_a` = `opnd_b`) gives 0 with `clamped` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First unsigned operand (minuend when subtracting) |
| opnd_b | input | WIDTH | Second unsigned operand (subtrahend when subtracting) |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | WIDTH | Clamped sum or difference |
| clamped | output | 1 | High when the result was forced to a limit |
| carry_out | output | 1 | Raw carry out of the most significant stage |

## Verification
The bench builds the block with its default WIDTH of 8. At that width the input space is only 2^17 points, so every combination of both operands and the mode bit is applied and compared with a behavioural clamp model. A handful of directed limit cases run first: exact-fit sums, equal operands, and the extreme overflow and underflow points. This makes the randomness of operand choice moot at this width. Every overflow boundary and every borrow boundary is reached deterministically.

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] result,
  output logic             clamped,
  output logic             carry_out
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ALL_ZERO = '0;

  always_comb begin
    logic [WIDTH:0]   cy;
    logic [WIDTH-1:0] bx;
    logic [WIDTH-1:0] raw;
    logic [WIDTH-1:0] fill;
    cy[0] = sub_mode;
    for (int i = 0; i < WIDTH; i++) begin
      bx[i]    = opnd_b[i] ^ sub_mode;
      raw[i]   = opnd_a[i] ^ bx[i] ^ cy[i];
      cy[i+1]  = (opnd_a[i] & bx[i]) | (bx[i] & cy[i]) | (opnd_a[i] & cy[i]);
    end
    carry_out = cy[WIDTH];
    clamped   = cy[WIDTH] ^ sub_mode;
    fill      = sub_mode ? ALL_ZERO : ALL_ONES;
    for (int i = 0; i < WIDTH; i++) begin
      result[i] = clamped ? fill[i] : raw[i];
    end

    // R2
    ovf_clamp_chk: assert (sub_mode || !carry_out || result == ALL_ONES);
    // R4
    neg_clamp_chk: assert (!sub_mode || carry_out || result == ALL_ZERO);
    // R1 R3 R7
    pass_thru_chk: assert (clamped ||
      result == WIDTH'(sub_mode ? opnd_a - opnd_b : opnd_a + opnd_b));
    // R5
    carry_ref_chk: assert (carry_out == (sub_mode ? (opnd_a >= opnd_b) :
      (({1'b0, opnd_a} + {1'b0, opnd_b}) > {1'b0, ALL_ONES})));
  end

endmodule

// File: tb/test_sat_addsub.sv
module test_sat_addsub;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a, b;
  logic       s;
  logic [7:0] res;
  logic       flg, cout;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done  = 0;

  always #10 clk = ~clk;

  sat_addsub #(.WIDTH(8)) i_sat_addsub (
    .opnd_a(a), .opnd_b(b), .sub_mode(s),
    .result(res), .clamped(flg), .carry_out(cout)
  );

  function automatic logic [9:0] model(int x, int y, bit m);
    if (!m) begin
      if (x + y > 255) return {1'b1, 1'b1, 8'hFF};
      return {1'b0, 1'b0, 8'(x + y)};
    end
    if (x >= y) return {1'b1, 1'b0, 8'(x - y)};
    return {1'b0, 1'b1, 8'h00};
  endfunction

  function automatic string tag_of(int x, int y, bit m);
    if (!m && x + y == 255) return "R7";
    if (m && x == y) return "R7";
    if (!m) return (x + y > 255) ? "R2" : "R1";
    return (x >= y) ? "R3" : "R4";
  endfunction

  task automatic apply(int x, int y, bit m, string tag);
    logic [9:0] e;
    @(posedge clk);
    #2;
    a = 8'(x); b = 8'(y); s = m;
    @(negedge clk);
    e = model(x, y, m);
    n_vec++;
    if (res !== e[7:0] || flg !== e[8] || cout !== e[9]) begin
      n_bad++;
      if (res !== e[7:0])
        $display("FAIL %s a=%0d b=%0d sub=%0d result=%0d expected %0d", tag, x, y, m, res, e[7:0]);
      if (flg !== e[8])
        $display("FAIL R6 a=%0d b=%0d sub=%0d clamped=%0d expected %0d", x, y, m, flg, e[8]);
      if (cout !== e[9])
        $display("FAIL R5 a=%0d b=%0d sub=%0d carry_out=%0d expected %0d", x, y, m, cout, e[9]);
    end
  endtask

  initial begin
    a = '0; b = '0; s = 1'b0;
    repeat (3) @(posedge clk);
    apply(0, 0, 1'b0, "R1");
    rst = 1'b0;
    apply(255, 0, 1'b0, "R7");
    apply(100, 155, 1'b0, "R7");
    apply(128, 128, 1'b0, "R2");
    apply(255, 255, 1'b0, "R2");
    apply(0, 0, 1'b1, "R7");
    apply(0, 1, 1'b1, "R4");
    apply(0, 255, 1'b1, "R4");
    apply(255, 255, 1'b1, "R7");
    apply(200, 57, 1'b1, "R3");
    for (int m = 0; m < 2; m++)
      for (int x = 0; x < 256; x++)
        for (int y = 0; y < 256; y++)
          apply(x, y, bit'(m), tag_of(x, y, bit'(m)));
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired after %0d vectors, expected completion", n_vec);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule